// File: doc/BRIEF.md
# Configuration Register Byte-Lane Access Unit

This block stands between a requester of configuration accesses and a bank of 32-bit configuration registers held for a small set of device slots. Each request names a slot, a register index within the slot, a starting byte lane (0 to 3) and a width of 1, 2 or 4 bytes. Every width is accepted at every starting lane. Lanes that run past lane 3 wrap back to lane 0, so a value written at a given width and lane always reads back unchanged at that same width and lane.

Reads are combinational. The selected bytes come back right-justified. A slot with no device answers with all ones. A register index past the implemented ones answers with zero. Writes merge the new bytes into the stored dword on the clock edge and leave the other lanes alone. A request whose starting lane is not a multiple of its width still completes, and it raises a one-cycle error strobe.

Top module: `cfg_lane_unit`

## Requirements
- R1: The width code on `req_size` means 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes. Code 2'b11 behaves exactly like 2'b10. The start lane `req_offs` takes any value from 0 to 3 with every width.
- R2: A read returns the byte of the start lane in `rd_data[7:0]`, with the following lanes in ascending significance. Bits above the access width read as zero.
- R3: Lane numbers past 3 wrap modulo 4. For example, a 2-byte read at lane 3 of 0x12345678 returns 0x7812, and a 4-byte read at lane 2 returns 0x56781234.
- R4: A write places `req_wdata[7:0]` in the start lane and the following data bytes in the following (wrapped) lanes. Lanes outside the access keep their stored value.
- R5: A 4-byte write replaces all four lanes at any start lane. A 4-byte write of 0x11223344 at lane 1 stores 0x22334411.
- R6: After a write at a given slot, register, width and lane, a read with the same four values returns the written data, masked to the width.
- R7: A slot number at or above NUM_DEV drives `dev_present` low and reads as 0xFFFFFFFF. A write to such a slot changes no stored register.
- R8: In a present slot, a register index at or above NUM_REGS reads as zero, and writes to it are discarded.
- R9: A valid request whose start lane is not a multiple of its width raises `err_pulse` for exactly the following cycle. These are a 2-byte access at lane 1 or 3, and a 4-byte access at lane 1, 2 or 3. A 1-byte access never raises it. The access is still performed.
- R10: After reset all stored registers are zero and `err_pulse` is low.
- R11: A write takes effect on the rising clock edge. During the write cycle, `rd_data` still shows the value stored before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_slot | input | SLOT_W | Device slot number |
| req_reg | input | REG_W | Dword register index within the slot |
| req_offs | input | 2 | Starting byte lane |
| req_size | input | 2 | Width code (see R1) |
| req_wdata | input | 32 | Right-justified write data |
| rd_data | output | 32 | Right-justified read result, combinational |
| dev_present | output | 1 | Addressed slot holds a device |
| err_pulse | output | 1 | One-cycle strobe for a misaligned request |

## Verification
Three things are due on three different cycles. `rd_data` and `dev_present` follow the request inputs in the same cycle. A write becomes visible only after the next rising edge. `err_pulse` rises one edge after the request and falls one edge later. The bench drives each request on a falling edge. It checks `rd_data` and `dev_present` a moment later, in the same cycle; during a write this is the pre-write value. It checks `err_pulse` on the following falling edge, after exactly one register stage, and only then updates its reference model. A random mix of widths, lanes, slots and registers is checked against bench functions, together with directed cases for wrap-around, missing slots, unused registers and the width of the strobe.

// File: rtl/cfg_lane_pkg.sv
package cfg_lane_pkg;

    localparam int CFG_LANES = 4;
    localparam int CFG_DW    = 8 * CFG_LANES;

    typedef enum logic [1:0] {
        CFG_SZ1     = 2'b00,
        CFG_SZ2     = 2'b01,
        CFG_SZ4     = 2'b10,
        CFG_SZ4_ALT = 2'b11
    } cfg_size_e;

    // Number of byte lanes an access of the given width touches (R1)
    function automatic logic [2:0] lane_count(input logic [1:0] code);
        case (cfg_size_e'(code))
            CFG_SZ1: return 3'd1;
            CFG_SZ2: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/cfg_lane_extract.sv
module cfg_lane_extract
    import cfg_lane_pkg::*;
(
    input  logic [CFG_DW-1:0] word_i,
    input  logic [1:0]        offs_i,
    input  logic [1:0]        size_i,
    output logic [CFG_DW-1:0] data_o
);
    logic [2:0] nbytes;
    assign nbytes = lane_count(size_i);

    // Output byte k takes stored lane (offs + k) mod 4 (R2, R3)
    for (genvar k = 0; k < CFG_LANES; k++) begin : g_out
        logic [1:0] src;
        assign src = offs_i + 2'(k);
        assign data_o[8*k +: 8] = (3'(k) < nbytes) ? word_i[8*src +: 8] : 8'h00;
    end
endmodule

// File: rtl/cfg_lane_merge.sv
module cfg_lane_merge
    import cfg_lane_pkg::*;
(
    input  logic [CFG_DW-1:0] word_i,
    input  logic [CFG_DW-1:0] wdata_i,
    input  logic [1:0]        offs_i,
    input  logic [1:0]        size_i,
    output logic [CFG_DW-1:0] word_o
);
    logic [2:0] nbytes;
    assign nbytes = lane_count(size_i);

    // Stored lane j is fed from data byte (j - offs) mod 4 when inside the access (R4, R5)
    for (genvar j = 0; j < CFG_LANES; j++) begin : g_lane
        logic [1:0] rel;
        logic       en;
        assign rel = 2'(j) - offs_i;
        assign en  = {1'b0, rel} < nbytes;
        assign word_o[8*j +: 8] = en ? wdata_i[8*rel +: 8] : word_i[8*j +: 8];
    end
endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
    import cfg_lane_pkg::*;
(
    input  logic [1:0] offs_i,
    input  logic [1:0] size_i,
    output logic       misaligned_o
);
    always_comb begin
        case (cfg_size_e'(size_i))
            CFG_SZ1: misaligned_o = 1'b0;
            CFG_SZ2: misaligned_o = offs_i[0];
            default: misaligned_o = (offs_i != 2'd0);
        endcase
    end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
    import cfg_lane_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int NUM_REGS = 8,
    parameter int SLOT_W   = 4,
    parameter int REG_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [1:0]        req_offs,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic              dev_present,
    output logic              err_pulse
);
    localparam int ENTRIES = NUM_DEV * NUM_REGS;
    localparam int ENTRY_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0][CFG_DW-1:0] regs;
        logic                           err;
    } state_t;

    state_t state_d, state_q;

    logic               dev_hit, reg_hit;
    logic [ENTRY_W-1:0] entry_idx;
    logic [CFG_DW-1:0]  cur_word, picked, merged;
    logic               misaligned;

    assign dev_hit   = 32'(req_slot) < 32'(NUM_DEV);
    assign reg_hit   = 32'(req_reg) < 32'(NUM_REGS);
    assign entry_idx = (dev_hit && reg_hit)
                     ? ENTRY_W'(32'(req_slot) * 32'(NUM_REGS) + 32'(req_reg))
                     : '0;
    assign cur_word  = state_q.regs[entry_idx];

    cfg_lane_extract u_extract (
        .word_i (cur_word),
        .offs_i (req_offs),
        .size_i (req_size),
        .data_o (picked)
    );

    cfg_lane_merge u_merge (
        .word_i  (cur_word),
        .wdata_i (req_wdata),
        .offs_i  (req_offs),
        .size_i  (req_size),
        .word_o  (merged)
    );

    cfg_lane_align u_align (
        .offs_i       (req_offs),
        .size_i       (req_size),
        .misaligned_o (misaligned)
    );

    always_comb begin
        state_d     = state_q;
        state_d.err = req_valid && misaligned;
        if (req_valid && req_write && dev_hit && reg_hit) begin
            state_d.regs[entry_idx] = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (!dev_hit) begin
            rd_data = '1;
        end else if (!reg_hit) begin
            rd_data = '0;
        end else begin
            rd_data = picked;
        end
    end

    assign dev_present = dev_hit;
    assign err_pulse   = state_q.err;
endmodule

// File: rtl/cfg_lane_unit_chk.sv
module cfg_lane_unit_chk #(
    parameter int NUM_DEV  = 4,
    parameter int NUM_REGS = 8,
    parameter int SLOT_W   = 4,
    parameter int REG_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [SLOT_W-1:0] req_slot,
    input logic [REG_W-1:0]  req_reg,
    input logic [1:0]        req_offs,
    input logic [1:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic [31:0]       rd_data,
    input logic              dev_present,
    input logic              err_pulse
);
    logic bad_align;
    logic wide_at_zero;
    logic usable;

    assign bad_align    = (req_size == 2'b01 && req_offs[0]) || (req_size[1] && req_offs != 2'd0);
    assign wide_at_zero = req_size == 2'b10 && req_offs == 2'd0;
    assign usable       = 32'(req_slot) < 32'(NUM_DEV) && 32'(req_reg) < 32'(NUM_REGS);

    // R7
    missing_dev_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(req_slot) >= 32'(NUM_DEV)) |-> (!dev_present && rd_data == 32'hFFFF_FFFF));

    // R9
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_align) |=> err_pulse);

    // R9
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(req_valid && bad_align));

    // R9
    byte_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |=> !err_pulse);

    // R6
    full_roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && wide_at_zero && usable)
        |=> (($stable(req_slot) && $stable(req_reg) && wide_at_zero)
             -> (rd_data == $past(req_wdata))));
endmodule

bind cfg_lane_unit cfg_lane_unit_chk #(
    .NUM_DEV  (NUM_DEV),
    .NUM_REGS (NUM_REGS),
    .SLOT_W   (SLOT_W),
    .REG_W    (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_slot    (req_slot),
    .req_reg     (req_reg),
    .req_offs    (req_offs),
    .req_size    (req_size),
    .req_wdata   (req_wdata),
    .rd_data     (rd_data),
    .dev_present (dev_present),
    .err_pulse   (err_pulse)
);

// File: tb/cfg_lane_unit_bench.sv
module cfg_lane_unit_bench;
    localparam int NUM_DEV  = 4;
    localparam int NUM_REGS = 8;
    localparam int SLOT_W   = 4;
    localparam int REG_W    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [SLOT_W-1:0] req_slot = '0;
    logic [REG_W-1:0]  req_reg = '0;
    logic [1:0]        req_offs = '0;
    logic [1:0]        req_size = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rd_data;
    logic              dev_present;
    logic              err_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] model [NUM_DEV][NUM_REGS];

    always #5 clk = ~clk;

    cfg_lane_unit #(
        .NUM_DEV(NUM_DEV), .NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W), .REG_W(REG_W)
    ) u_cfg_lane_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_slot(req_slot), .req_reg(req_reg), .req_offs(req_offs),
        .req_size(req_size), .req_wdata(req_wdata), .rd_data(rd_data),
        .dev_present(dev_present), .err_pulse(err_pulse)
    );

    function automatic int width_of(input int code);
        if (code == 0) return 1;
        if (code == 1) return 2;
        return 4;
    endfunction

    function automatic bit exp_misal(input int offs, input int code);
        return (offs % width_of(code)) != 0;
    endfunction

    function automatic logic [31:0] ref_read(input logic [31:0] w, input int offs, input int code);
        logic [31:0] r = '0;
        for (int i = 0; i < width_of(code); i++) r[8*i +: 8] = w[8*((offs + i) % 4) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] ref_write(input logic [31:0] w, input logic [31:0] wd,
                                              input int offs, input int code);
        logic [31:0] r = w;
        for (int i = 0; i < width_of(code); i++) r[8*((offs + i) % 4) +: 8] = wd[8*i +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input int slot, input int rg, input int offs, input int code);
        if (slot >= NUM_DEV) return 32'hFFFF_FFFF;
        if (rg >= NUM_REGS) return 32'h0;
        return ref_read(model[slot][rg], offs, code);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Drive one request on a falling edge, check same-cycle outputs, then the strobe one edge later
    task automatic access(input bit wr, input int slot, input int rg, input int offs, input int code,
                          input logic [31:0] wd, input string tag);
        logic [31:0] e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_slot  = SLOT_W'(slot);
        req_reg   = REG_W'(rg);
        req_offs  = 2'(offs);
        req_size  = 2'(code);
        req_wdata = wd;
        #1;
        e = exp_rd(slot, rg, offs, code);
        check(wr ? {tag, " R11 pre-write value"} : tag, rd_data, e);
        check({tag, " R7 presence"}, {31'd0, dev_present}, {31'd0, slot < NUM_DEV});
        @(negedge clk);
        check({tag, " R9 strobe"}, {31'd0, err_pulse}, {31'd0, exp_misal(offs, code)});
        if (wr && slot < NUM_DEV && rg < NUM_REGS)
            model[slot][rg] = ref_write(model[slot][rg], wd, offs, code);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < NUM_DEV; d++)
            for (int r = 0; r < NUM_REGS; r++) model[d][r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        check("R10 strobe low after reset", {31'd0, err_pulse}, 32'd0);
        access(0, 0, 0, 0, 2, 0, "R10 reg 0.0 zero");
        access(0, NUM_DEV - 1, NUM_REGS - 1, 0, 2, 0, "R10 last reg zero");

        // R2: full write then per-byte reads
        access(1, 0, 1, 0, 2, 32'h1234_5678, "R5 full write lane 0");
        access(0, 0, 1, 0, 0, 0, "R2 byte lane 0");
        access(0, 0, 1, 1, 0, 0, "R2 byte lane 1");
        access(0, 0, 1, 2, 0, 0, "R2 byte lane 2");
        access(0, 0, 1, 3, 0, 0, "R2 byte lane 3");
        access(0, 0, 1, 2, 1, 0, "R2 half lane 2");
        // R3 wrap reads
        access(0, 0, 1, 3, 1, 0, "R3 half lane 3");
        check("R3 half lane 3 literal", ref_read(model[0][1], 3, 1), 32'h0000_7812);
        access(0, 0, 1, 2, 2, 0, "R3 dword lane 2");
        check("R3 dword lane 2 literal", ref_read(model[0][1], 2, 2), 32'h5678_1234);
        access(0, 0, 1, 1, 1, 0, "R9 misaligned half read");
        // R4 partial writes
        access(1, 0, 1, 2, 0, 32'hFFFF_FFAB, "R4 byte write lane 2");
        access(0, 0, 1, 0, 2, 0, "R4 after byte write");
        check("R4 byte write literal", model[0][1], 32'h12AB_5678);
        access(1, 0, 1, 3, 1, 32'hFFFF_CDEF, "R4 half write lane 3");
        access(0, 0, 1, 0, 2, 0, "R4 after wrapped half write");
        check("R4 wrapped half literal", model[0][1], 32'hEFAB_56CD);
        // R5 full write at a nonzero lane
        access(1, 0, 1, 1, 2, 32'h1122_3344, "R5 full write lane 1");
        access(0, 0, 1, 0, 2, 0, "R5 after rotated full write");
        check("R5 rotated literal", model[0][1], 32'h2233_4411);
        // R1 code 3 acts as 4 bytes
        access(0, 0, 1, 0, 3, 0, "R1 code 3 read lane 0");
        access(0, 0, 1, 2, 3, 0, "R1 code 3 read lane 2");
        access(1, 0, 2, 0, 3, 32'hCAFE_BABE, "R1 code 3 write");
        access(0, 0, 2, 0, 2, 0, "R1 code 3 write result");
        // R7 missing slot
        access(0, NUM_DEV, 1, 0, 2, 0, "R7 missing slot read");
        access(1, NUM_DEV, 1, 0, 2, 32'hDEAD_BEEF, "R7 missing slot write");
        access(0, 0, 1, 0, 2, 0, "R7 alias slot untouched");
        access(0, (1 << SLOT_W) - 1, 0, 1, 0, 0, "R7 highest slot read");
        // R8 unused register
        access(1, 1, NUM_REGS, 0, 2, 32'h5555_AAAA, "R8 unused reg write");
        access(0, 1, NUM_REGS, 0, 2, 0, "R8 unused reg reads zero");
        access(0, 1, 0, 0, 2, 0, "R8 neighbour untouched");
        // R9 strobe lasts one cycle
        access(0, 2, 0, 3, 2, 0, "R9 misaligned dword");
        @(negedge clk);
        check("R9 strobe falls after one cycle", {31'd0, err_pulse}, 32'd0);
        access(1, 2, 3, 1, 2, 32'h0BAD_F00D, "R9 misaligned write still lands");
        access(0, 2, 3, 1, 2, 0, "R6 misaligned roundtrip");

        // Random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            int slot = $urandom_range(NUM_DEV, 0);
            int rg   = $urandom_range(NUM_REGS, 0);
            int offs = $urandom_range(3, 0);
            int code = $urandom_range(3, 0);
            logic [31:0] wd = $urandom;
            if ($urandom_range(1, 0) == 1) begin
                access(1, slot, rg, offs, code, wd, "R4 random write");
                if (slot < NUM_DEV && rg < NUM_REGS) begin
                    access(0, slot, rg, offs, code, 0, "R6 random roundtrip");
                    check("R6 random roundtrip literal", ref_read(model[slot][rg], offs, code),
                          ref_read(wd, 0, code));
                end
            end else begin
                access(0, slot, rg, offs, code, 0, "R2 random read");
            end
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule